// File: doc/BRIEF.md
# Four-Stage Interlocked In-Order Pipeline

This block runs a small 16-bit instruction set through four stages: fetch, decode, execute and result store. Each stage takes one cycle when it is not stalled. No operand is forwarded and no branch is predicted. The block resolves each hazard by holding the stages behind it:

- **Fetch misses.** A fetch that misses costs a fixed number of extra cycles.
- **Conditional branches.** A fetched conditional branch blocks all later fetches until it has left the result-store stage.
- **Register dependencies.** An instruction whose source register is still being produced waits in decode. It waits until the producer reaches result store, where the register file writes in the first half of the cycle.

The instruction memory sits outside the block. The block presents a fetch address and receives the instruction word with a miss flag for that address. Each completed instruction produces a one-cycle retire report. The report carries the instruction's address and the cycle number in which it completed. The first cycle after reset is cycle 1. The report lets a caller compare actual occupancy against an expected stage-by-time chart.

Top module: `inorder_pipe4`

## Requirements
- R1: While reset is high, and in the three cycles after it, no retire is reported. The cycle counter reads 1 in the first cycle after reset. Each register i of the eight-entry register file holds the value i after reset.
- R2: With no hazard, instruction k (counting from 1) of a straight run retires in cycle k+3, so ten instructions finish in cycle 13.
- R3: A fetch whose miss flag is set holds fetch for MISS_PEN (default 3) extra cycles, and every later instruction slips by the same amount. Ten instructions with a miss on the second finish in cycle 16.
- R4: Once a branch (opcode 4) is fetched, nothing further is fetched until the cycle after the branch has been in result store, whether or not the branch is taken. A not-taken branch continues at the next sequential address.
- R5: During a decode stall, the decode stage keeps its instruction and the fetch stage issues nothing. The execute stage receives a bubble.
- R6: An instruction waits in decode while the instruction in execute writes one of its source registers. A read in the same cycle as the producing write in result store sees the new value.
- R7: A branch tests the register in bits [11:9]. When that register is negative, fetch resumes at the branch address plus the sign-extended offset in bits [8:0].
- R8: Opcode sits in bits [15:12]; destination in [11:9]. Opcode 1 writes [8:6]+[5:3] and opcode 2 writes [8:6]−[5:3]. Opcode 3 shifts the register in [11:9] left by one in place, filling with zero. Opcode 0 and the branch write nothing.
- R9: The retire port pulses once per completed instruction. It gives the instruction address and the cycle number, plus the write enable, destination and value for any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | PC_W | Address of the instruction being fetched |
| imemData | input | 16 | Instruction word at imemAddr |
| imemMiss | input | 1 | Miss flag for the word at imemAddr |
| retireValid | output | 1 | One-cycle pulse per completed instruction |
| retirePc | output | PC_W | Address of the completed instruction |
| retireCycle | output | CYC_W | Cycle number of completion |
| retireWen | output | 1 | Completed instruction wrote a register |
| retireDst | output | 3 | Register written |
| retireData | output | DATA_W | Value written |

## Verification
The bench builds the block with its defaults: 16-bit data, 10-bit addresses, a 16-bit cycle counter and a miss penalty of 3. These values let the bench compare retire cycles directly against hand-drawn occupancy charts for straight runs, a miss, an untaken branch, a data dependency, and a taken branch that itself waits on a dependency. The bench reads results through the retire port. A subtraction of small reset values gives the negative number that drives the taken branch.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_N   = 8;
  localparam int REG_AW  = 3;
  localparam int OFF_W   = 9;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_SHL = 4'd3,
    OP_BRN = 4'd4
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fetch;
    logic stallD;
    logic redirect;
  } ctl_s;

  // status from datapath to control
  typedef struct packed {
    logic              dValid;
    logic [REG_AW-1:0] dSrcA;
    logic [REG_AW-1:0] dSrcB;
    logic              dUsesA;
    logic              dUsesB;
    logic              eValid;
    logic              eWen;
    logic [REG_AW-1:0] eDst;
    logic              sValid;
    logic              sIsBr;
    logic              fetchIsBr;
  } sts_s;

  function automatic logic isBr(input logic [INSTR_W-1:0] i);
    return i[15:12] == OP_BRN;
  endfunction

  function automatic logic writesReg(input logic [INSTR_W-1:0] i);
    return (i[15:12] == OP_ADD) || (i[15:12] == OP_SUB) || (i[15:12] == OP_SHL);
  endfunction

  function automatic logic usesA(input logic [INSTR_W-1:0] i);
    return writesReg(i) || isBr(i);
  endfunction

  function automatic logic usesB(input logic [INSTR_W-1:0] i);
    return (i[15:12] == OP_ADD) || (i[15:12] == OP_SUB);
  endfunction

  function automatic logic [REG_AW-1:0] srcA(input logic [INSTR_W-1:0] i);
    return ((i[15:12] == OP_SHL) || isBr(i)) ? i[11:9] : i[8:6];
  endfunction

  function automatic logic [REG_AW-1:0] srcB(input logic [INSTR_W-1:0] i);
    return i[5:3];
  endfunction
endpackage

// File: rtl/pipe4_ctrl.sv
module pipe4_ctrl
  import pipe4_pkg::*;
#(
  parameter int MISS_PEN = 3,
  parameter int CYC_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  sts_s             sts,
  input  logic             imemMiss,
  output ctl_s             ctl,
  output logic [CYC_W-1:0] cycleCnt
);
  localparam int MC_W = (MISS_PEN < 1) ? 1 : $clog2(MISS_PEN + 1);

  logic            brPending;
  logic [MC_W-1:0] missCnt;
  logic            hazard;
  logic            canFetch;
  logic            missWait;

  always_comb begin
    hazard = sts.dValid && sts.eValid && sts.eWen &&
             ((sts.dUsesA && (sts.dSrcA == sts.eDst)) ||
              (sts.dUsesB && (sts.dSrcB == sts.eDst)));
    canFetch = !brPending && !hazard;
    missWait = canFetch && imemMiss && (missCnt != MC_W'(MISS_PEN));
    ctl.fetch    = canFetch && !missWait;
    ctl.stallD   = hazard;
    ctl.redirect = sts.sValid && sts.sIsBr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brPending <= 1'b0;
      missCnt   <= '0;
      cycleCnt  <= CYC_W'(1);
    end else begin
      cycleCnt <= cycleCnt + CYC_W'(1);
      if (missWait)       missCnt <= missCnt + MC_W'(1);
      else if (ctl.fetch) missCnt <= '0;
      if (ctl.fetch && sts.fetchIsBr)    brPending <= 1'b1;
      else if (sts.sValid && sts.sIsBr)  brPending <= 1'b0;
    end
  end

  // R4: a branch in result store was fetched under the block
  p_branch_block_r4: assert property (@(posedge clk) disable iff (rst)
    (sts.sValid && sts.sIsBr) |-> brPending);

  // R4: fetch resumes only after the branch has left result store
  p_resume_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(brPending) |-> $past(sts.sValid && sts.sIsBr));
endmodule

// File: rtl/pipe4_dpath.sv
module pipe4_dpath
  import pipe4_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PC_W     = 10,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_s              ctl,
  output sts_s              sts,
  output logic [PC_W-1:0]   imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic              retireValid,
  output logic [PC_W-1:0]   retirePc,
  output logic              retireWen,
  output logic [REG_AW-1:0] retireDst,
  output logic [DATA_W-1:0] retireData
);
  logic [DATA_W-1:0]  regFile [REG_N];
  logic [PC_W-1:0]    fetchPc;
  logic               dValid, eValid, sValid;
  logic [INSTR_W-1:0] dInstr, eInstr;
  logic [PC_W-1:0]    dPc, ePc, sPc, sTarget;
  logic [DATA_W-1:0]  eOpA, eOpB, sResult, rdA, rdB, aluOut;
  logic               sWen, sIsBr, sTaken;
  logic [REG_AW-1:0]  sDst;
  logic [PC_W-1:0]    brOff;

  // register file, written first in the cycle
  always_comb begin
    rdA = (sValid && sWen && (sDst == srcA(dInstr))) ? sResult : regFile[srcA(dInstr)];
    rdB = (sValid && sWen && (sDst == srcB(dInstr))) ? sResult : regFile[srcB(dInstr)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < REG_N; k++) regFile[k] <= DATA_W'(k);
    end else if (sValid && sWen) begin
      regFile[sDst] <= sResult;
    end
  end

  // fetch and decode
  assign imemAddr = fetchPc;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchPc <= PC_W'(RESET_PC);
      dValid  <= 1'b0;
      dInstr  <= '0;
      dPc     <= '0;
    end else begin
      if (ctl.redirect && sTaken) fetchPc <= sTarget;
      else if (ctl.fetch)         fetchPc <= fetchPc + PC_W'(1);
      if (!ctl.stallD) begin
        dValid <= ctl.fetch;
        if (ctl.fetch) begin
          dInstr <= imemData;
          dPc    <= fetchPc;
        end
      end
    end
  end

  // execute
  always_comb begin
    unique case (eInstr[15:12])
      OP_ADD:  aluOut = eOpA + eOpB;
      OP_SUB:  aluOut = eOpA - eOpB;
      OP_SHL:  aluOut = {eOpA[DATA_W-2:0], 1'b0};
      default: aluOut = '0;
    endcase
    brOff = {{(PC_W-OFF_W){eInstr[OFF_W-1]}}, eInstr[OFF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eValid <= 1'b0;
      sValid <= 1'b0;
    end else begin
      eValid <= dValid && !ctl.stallD;
      sValid <= eValid;
    end
    eInstr  <= dInstr;
    ePc     <= dPc;
    eOpA    <= rdA;
    eOpB    <= rdB;
    sPc     <= ePc;
    sWen    <= eValid && writesReg(eInstr);
    sDst    <= eInstr[11:9];
    sResult <= aluOut;
    sIsBr   <= isBr(eInstr);
    sTaken  <= isBr(eInstr) && eOpA[DATA_W-1];
    sTarget <= ePc + brOff;
  end

  always_comb begin
    sts.dValid    = dValid;
    sts.dSrcA     = srcA(dInstr);
    sts.dSrcB     = srcB(dInstr);
    sts.dUsesA    = usesA(dInstr);
    sts.dUsesB    = usesB(dInstr);
    sts.eValid    = eValid;
    sts.eWen      = writesReg(eInstr);
    sts.eDst      = eInstr[11:9];
    sts.sValid    = sValid;
    sts.sIsBr     = sIsBr;
    sts.fetchIsBr = isBr(imemData);
  end

  assign retireValid = sValid;
  assign retirePc    = sPc;
  assign retireWen   = sValid && sWen;
  assign retireDst   = sDst;
  assign retireData  = sResult;

  // R5: decode holds its contents through a stall
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.stallD |=> dValid && $stable(dInstr) && $stable(dPc));

  // R5: a stall sends a bubble into execute
  p_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.stallD |=> !eValid);

  // R6: no instruction read a register its predecessor had not yet stored
  p_dep_order_r6: assert property (@(posedge clk) disable iff (rst)
    !(eValid && sValid && sWen &&
      ((usesA(eInstr) && (srcA(eInstr) == sDst)) ||
       (usesB(eInstr) && (srcB(eInstr) == sDst)))));

  // R4: at most one branch in flight
  p_one_branch_r4: assert property (@(posedge clk) disable iff (rst)
    $countones({dValid && isBr(dInstr), eValid && isBr(eInstr), sValid && sIsBr}) <= 1);
endmodule

// File: rtl/inorder_pipe4.sv
module inorder_pipe4
  import pipe4_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PC_W     = 10,
  parameter int CYC_W    = 16,
  parameter int MISS_PEN = 3,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   imemAddr,
  input  logic [15:0]       imemData,
  input  logic              imemMiss,
  output logic              retireValid,
  output logic [PC_W-1:0]   retirePc,
  output logic [CYC_W-1:0]  retireCycle,
  output logic              retireWen,
  output logic [2:0]        retireDst,
  output logic [DATA_W-1:0] retireData
);
  ctl_s ctl;
  sts_s sts;

  pipe4_ctrl #(.MISS_PEN(MISS_PEN), .CYC_W(CYC_W)) ctrl_i (
    .clk(clk), .rst(rst), .sts(sts), .imemMiss(imemMiss),
    .ctl(ctl), .cycleCnt(retireCycle)
  );

  pipe4_dpath #(.DATA_W(DATA_W), .PC_W(PC_W), .RESET_PC(RESET_PC)) dpath_i (
    .clk(clk), .rst(rst), .ctl(ctl), .sts(sts),
    .imemAddr(imemAddr), .imemData(imemData),
    .retireValid(retireValid), .retirePc(retirePc), .retireWen(retireWen),
    .retireDst(retireDst), .retireData(retireData)
  );
endmodule

// File: tb/inorder_pipe4_tb_top.sv
`timescale 1ns/100ps
module inorder_pipe4_tb_top;
  localparam int WD_CYCLES = 200000;
  localparam logic [15:0] ADD0   = {4'd1, 3'd0, 3'd1, 3'd2, 3'd0};
  localparam logic [15:0] BRN_NT = {4'd4, 3'd1, 9'd5};
  // {scenario, retire index (= address), expected cycle}
  localparam logic [15:0] VEC [12] = '{
    {4'd1, 4'd0, 8'd4},  {4'd1, 4'd1, 8'd5},  {4'd1, 4'd9, 8'd13},
    {4'd2, 4'd0, 8'd4},  {4'd2, 4'd1, 8'd8},  {4'd2, 4'd2, 8'd9},  {4'd2, 4'd9, 8'd16},
    {4'd3, 4'd2, 8'd6},  {4'd3, 4'd3, 8'd7},  {4'd3, 4'd4, 8'd11}, {4'd3, 4'd5, 8'd12},
    {4'd3, 4'd9, 8'd16}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  imemAddr;
  logic [15:0] imemData;
  logic        imemMiss;
  logic        retireValid, retireWen;
  logic [9:0]  retirePc;
  logic [15:0] retireCycle, retireData;
  logic [2:0]  retireDst;

  logic [15:0] mem [32];
  logic [31:0] missMask;
  int          checks = 0;
  int          failures = 0;
  int          logN = 0;
  logic [9:0]  logPc  [32];
  logic [15:0] logCyc [32];
  logic [15:0] logData[32];
  logic        logWen [32];
  logic [2:0]  logDst [32];

  always #2.5 clk = ~clk;

  assign imemData = mem[imemAddr[4:0]];
  assign imemMiss = missMask[imemAddr[4:0]];

  inorder_pipe4 dut_i (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData), .imemMiss(imemMiss),
    .retireValid(retireValid), .retirePc(retirePc), .retireCycle(retireCycle),
    .retireWen(retireWen), .retireDst(retireDst), .retireData(retireData)
  );

  always @(negedge clk) begin
    if (rst) logN = 0;
    else if (retireValid && logN < 32) begin
      logPc[logN] = retirePc;   logCyc[logN] = retireCycle;
      logData[logN] = retireData; logWen[logN] = retireWen; logDst[logN] = retireDst;
      logN++;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int k = 0; k < 32; k++) mem[k] = 16'h0000;
    missMask = '0;
  endtask

  task automatic runProg();
    @(negedge clk); #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    check(retireValid == 1'b0, "R1 no retire in reset", int'(retireValid), 0);
    #1 rst = 1'b0;
    repeat (26) @(negedge clk);
  endtask

  task automatic loadScen(input int s);
    clearMem();
    for (int k = 0; k < 10; k++) mem[k] = ADD0;
    if (s == 2) missMask[1] = 1'b1;
    if (s == 3) mem[3] = BRN_NT;
  endtask

  initial begin
    #(WD_CYCLES * 5);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cur;
    clearMem();
    cur = 0;
    // vector table: R2 straight run, R3 fetch miss, R4 untaken branch
    for (int i = 0; i < 12; i++) begin
      int s, idx, cyc;
      string tag;
      s = int'(VEC[i][15:12]); idx = int'(VEC[i][11:8]); cyc = int'(VEC[i][7:0]);
      tag = (s == 1) ? "R2" : (s == 2) ? "R3" : "R4";
      if (s != cur) begin
        loadScen(s); runProg(); cur = s;
        check(logN >= 10, {tag, " retire count"}, logN, 10);
      end
      check(int'(logPc[idx]) == idx, {tag, " retire address"}, int'(logPc[idx]), idx);
      check(int'(logCyc[idx]) == cyc, {tag, " retire cycle"}, int'(logCyc[idx]), cyc);
      if (!(s == 3 && idx == 3))
        check(logData[idx] == 16'd3, {tag, " R8 add of reset values"}, int'(logData[idx]), 3);
    end

    // R1: the first retire of a straight run lands in cycle 4
    loadScen(1); runProg();
    check(logCyc[0] == 16'd4, "R1 first cycle numbering", int'(logCyc[0]), 4);

    // R5 R6 R8: dependency stall and write-first read
    clearMem();
    mem[0] = {4'd1, 3'd3, 3'd1, 3'd2, 3'd0};
    mem[1] = {4'd3, 3'd3, 3'd0, 3'd0, 3'd0};
    mem[2] = {4'd2, 3'd4, 3'd5, 3'd6, 3'd0};
    runProg();
    check(logCyc[0] == 16'd4, "R6 producer cycle", int'(logCyc[0]), 4);
    check(logCyc[1] == 16'd6, "R6 dependent waits one cycle", int'(logCyc[1]), 6);
    check(logData[1] == 16'd6, "R6 R8 shift sees stored value", int'(logData[1]), 6);
    check(logCyc[2] == 16'd7, "R5 fetch held during stall", int'(logCyc[2]), 7);
    check(logData[2] == 16'hFFFF, "R8 subtract", int'(logData[2]), 65535);
    check(logWen[2] && logDst[2] == 3'd4, "R9 write report", int'(logDst[2]), 4);

    // R7: taken branch waiting on its tested register
    clearMem();
    mem[0] = {4'd2, 3'd0, 3'd1, 3'd2, 3'd0};
    mem[1] = {4'd4, 3'd0, 9'd3};
    mem[2] = {4'd1, 3'd7, 3'd1, 3'd1, 3'd0};
    mem[3] = {4'd1, 3'd7, 3'd1, 3'd1, 3'd0};
    mem[4] = {4'd1, 3'd5, 3'd1, 3'd2, 3'd0};
    runProg();
    check(logCyc[1] == 16'd6 && logPc[1] == 10'd1, "R7 branch retire cycle", int'(logCyc[1]), 6);
    check(logWen[1] == 1'b0, "R9 branch writes nothing", int'(logWen[1]), 0);
    check(logPc[2] == 10'd4, "R7 target address", int'(logPc[2]), 4);
    check(logCyc[2] == 16'd10, "R7 target retire cycle", int'(logCyc[2]), 10);
    check(logData[2] == 16'd3 && logDst[2] == 3'd5, "R8 add after redirect", int'(logData[2]), 3);
    check(logPc[3] == 10'd5 && logCyc[3] == 16'd11, "R9 sequential after target", int'(logPc[3]), 5);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule